// File: doc/BRIEF.md
# Eight-Lane Bus Bundle Repair Crossbar

This block sits on one segment of an on-chip bus and carries eight logical signal lanes across ten physical wires: eight main wires plus two spare wires. A small configuration state picks one of six fixed lane permutations, built from two switch columns. The first column applies one of three spreading patterns (straight, spread A, spread B), and the second column can swap every lane with its neighbour. Logical lanes 6 and 7 always travel on the two spare wires. The two main wires that the permutation would have given to those lanes stay idle and are driven low. Choosing a state therefore parks a chosen pair of main wires. This takes a broken wire out of service, or gives every active wire new neighbours to break up dynamic coupling.

Both ends of the segment are in the block. The sending map turns the logical lanes into wire values. The receiving map undoes the same permutation from the wires that arrive. Each map decodes the shared state register into its own column controls. A new state is taken only on a load strobe, and both maps switch on the same clock edge. A controller that has located a faulty main wire loads a state that parks that wire, and from then on the lanes arrive intact whatever the wire carries.

Top module: `bundle_repair_switch`

## Requirements
- R1: After reset the state is 0 (straight): lane i (i = 0..5) drives main wire i, lanes 6 and 7 drive spare wires 8 and 9, and main wires 6 and 7 are low.
- R2: State 1 (spread A) sends lanes 0..5 to main wires 2, 6, 0, 5, 7, 3 respectively.
- R3: State 2 (spread B) sends lanes 0..5 to main wires 3, 5, 7, 0, 6, 1 respectively.
- R4: State 3 (neighbour swap) sends lane i (i = 0..5) to main wire i XOR 1.
- R5: States 4 and 5 first apply spread A or spread B, then the neighbour swap (wire index XOR 1), to lanes 0..5.
- R6: In every state lanes 6 and 7 appear on wires 8 and 9, and the two main wires not used by lanes 0..5 are driven 0.
- R7: With the received wires equal to the sent wires, the received lanes equal the sent lanes in every state.
- R8: In each state, any value on a parked main wire has no effect on the received lanes.
- R9: The state changes only on a clock edge with the load strobe high, and the sending and receiving maps use the new state from the same edge.
- R10: A load that requests state 6 or 7 is ignored, and the previous state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the configuration state |
| cfg_state | input | 3 | Requested permutation state (0 to 5 are valid) |
| tx_data | input | 8 | Logical lanes entering the sending end |
| tx_wires | output | 10 | Physical wires driven by the sending end (8 main, 2 spare) |
| rx_wires | input | 10 | Physical wires arriving at the receiving end |
| rx_data | output | 8 | Logical lanes recovered at the receiving end |

## Verification
The bench goes through all six states and forces each parked wire to a stuck-high value. A design that parked the wrong wire, or read a lane back from a permuted position instead of the inverse one, would return a corrupted lane. The wire-level checks use patterns with single and mixed set bits. These catch a map that drives an idle wire, duplicates a lane onto two wires, or leaves the spare lanes on main wires. Loads that request states 6 and 7, and a changed request with the strobe low, must leave the old mapping in place; a register that took either would send data down the wrong wires. A reset in the middle of the run must bring back the straight mapping.

// File: rtl/bundle_repair_pkg.sv
package bundle_repair_pkg;

    localparam int unsigned LINES   = 8;
    localparam int unsigned SPARES  = 2;
    localparam int unsigned WIRES   = LINES + SPARES;
    localparam int unsigned KEPT    = LINES - SPARES;
    localparam int unsigned NSTATES = 6;
    localparam int unsigned STW     = $clog2(NSTATES);
    localparam int unsigned WIW     = $clog2(WIRES);
    localparam int unsigned LW      = $clog2(LINES);

    typedef logic [STW-1:0] state_t;

    typedef enum logic [1:0] {
        COL_STRAIGHT = 2'd0,
        COL_SPREAD_A = 2'd1,
        COL_SPREAD_B = 2'd2
    } col1_e;

    typedef struct packed {
        col1_e col1;
        logic  col2_swap;
    } sw_ctrl_t;

    // state -> column controls; out-of-range codes fall back to straight
    function automatic sw_ctrl_t decode_state(state_t s);
        sw_ctrl_t c;
        case (s)
            3'd1:    c = '{col1: COL_SPREAD_A, col2_swap: 1'b0};
            3'd2:    c = '{col1: COL_SPREAD_B, col2_swap: 1'b0};
            3'd3:    c = '{col1: COL_STRAIGHT, col2_swap: 1'b1};
            3'd4:    c = '{col1: COL_SPREAD_A, col2_swap: 1'b1};
            3'd5:    c = '{col1: COL_SPREAD_B, col2_swap: 1'b1};
            default: c = '{col1: COL_STRAIGHT, col2_swap: 1'b0};
        endcase
        return c;
    endfunction

    function automatic logic [LW-1:0] spread_a(logic [LW-1:0] i);
        logic [LW-1:0] o;
        case (i)
            3'd0: o = 3'd2;
            3'd1: o = 3'd6;
            3'd2: o = 3'd0;
            3'd3: o = 3'd5;
            3'd4: o = 3'd7;
            3'd5: o = 3'd3;
            3'd6: o = 3'd1;
            default: o = 3'd4;
        endcase
        return o;
    endfunction

    function automatic logic [LW-1:0] spread_b(logic [LW-1:0] i);
        logic [LW-1:0] o;
        case (i)
            3'd0: o = 3'd3;
            3'd1: o = 3'd5;
            3'd2: o = 3'd7;
            3'd3: o = 3'd0;
            3'd4: o = 3'd6;
            3'd5: o = 3'd1;
            3'd6: o = 3'd4;
            default: o = 3'd2;
        endcase
        return o;
    endfunction

    // physical wire carrying a logical lane under the given column controls
    function automatic logic [WIW-1:0] route(sw_ctrl_t c, logic [LW-1:0] lane);
        logic [LW-1:0] p;
        if (int'(lane) >= KEPT) begin
            return WIW'(int'(lane) - KEPT + LINES);
        end
        case (c.col1)
            COL_SPREAD_A: p = spread_a(lane);
            COL_SPREAD_B: p = spread_b(lane);
            default:      p = lane;
        endcase
        if (c.col2_swap) begin
            p = p ^ LW'(1);
        end
        return WIW'(p);
    endfunction

endpackage

// File: rtl/bundle_cfg_reg.sv
module bundle_cfg_reg
    import bundle_repair_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  state_t req_state,
    output state_t state_q
);

    typedef struct packed {
        state_t state;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load && (int'(req_state) < NSTATES)) begin
            cfg_d.state = req_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign state_q = cfg_q.state;

endmodule

// File: rtl/bundle_tx_map.sv
module bundle_tx_map
    import bundle_repair_pkg::*;
(
    input  state_t             state,
    input  logic [LINES-1:0]   data,
    output logic [WIRES-1:0]   wires
);

    sw_ctrl_t       ctrl;
    logic [WIW-1:0] dest [LINES];
    logic [LINES-1:0] sel [WIRES];

    assign ctrl = decode_state(state);

    for (genvar l = 0; l < LINES; l++) begin : g_lane
        assign dest[l] = route(ctrl, LW'(l));
    end

    for (genvar w = 0; w < WIRES; w++) begin : g_wire
        for (genvar l = 0; l < LINES; l++) begin : g_hit
            assign sel[w][l] = (dest[l] == WIW'(w));
        end
        assign wires[w] = |(sel[w] & data);
    end

endmodule

// File: rtl/bundle_rx_map.sv
module bundle_rx_map
    import bundle_repair_pkg::*;
(
    input  state_t             state,
    input  logic [WIRES-1:0]   wires,
    output logic [LINES-1:0]   data
);

    sw_ctrl_t       ctrl;
    logic [WIW-1:0] src [LINES];

    assign ctrl = decode_state(state);

    for (genvar l = 0; l < LINES; l++) begin : g_lane
        assign src[l]  = route(ctrl, LW'(l));
        assign data[l] = wires[src[l]];
    end

endmodule

// File: rtl/bundle_repair_switch.sv
module bundle_repair_switch
    import bundle_repair_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [STW-1:0]       cfg_state,
    input  logic [LINES-1:0]     tx_data,
    output logic [WIRES-1:0]     tx_wires,
    input  logic [WIRES-1:0]     rx_wires,
    output logic [LINES-1:0]     rx_data
);

    state_t state_q;

    bundle_cfg_reg cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .req_state (cfg_state),
        .state_q   (state_q)
    );

    bundle_tx_map tx_i (
        .state (state_q),
        .data  (tx_data),
        .wires (tx_wires)
    );

    bundle_rx_map rx_i (
        .state (state_q),
        .wires (rx_wires),
        .data  (rx_data)
    );

endmodule

// File: rtl/bundle_repair_checker.sv
module bundle_repair_checker
    import bundle_repair_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_load,
    input logic [STW-1:0]     cfg_state,
    input state_t             state_q,
    input logic [LINES-1:0]   tx_data,
    input logic [WIRES-1:0]   tx_wires,
    input logic [WIRES-1:0]   rx_wires,
    input logic [LINES-1:0]   rx_data
);

    a_r6_spare_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wires[WIRES-1:LINES] == tx_data[LINES-1:KEPT]);

    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tx_wires[LINES-1:0]) == $countones(tx_data[KEPT-1:0]));

    a_r7_loopback: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wires == tx_wires) |-> (rx_data == tx_data));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(state_q));

    a_r9_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (int'(cfg_state) < NSTATES)) |=> (state_q == $past(cfg_state)));

    a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (int'(cfg_state) >= NSTATES)) |=> $stable(state_q));

endmodule

bind bundle_repair_switch bundle_repair_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_state (cfg_state),
    .state_q   (state_q),
    .tx_data   (tx_data),
    .tx_wires  (tx_wires),
    .rx_wires  (rx_wires),
    .rx_data   (rx_data)
);

// File: tb/bundle_repair_switch_tb_top.sv
`timescale 1ns/1ps
module bundle_repair_switch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [2:0] cfg_state = 3'd0;
    logic [7:0] tx_data = 8'd0;
    logic [9:0] tx_wires;
    logic [9:0] rx_wires;
    logic [7:0] rx_data;

    logic       fault_en = 1'b0;
    int         fault_idx = 0;

    int tests = 0;
    int fails = 0;
    int model_state = 0;

    logic [9:0] q_w [$];
    logic [7:0] q_r [$];
    bit         q_cw [$];
    string      q_tw [$];
    string      q_tr [$];

    int spread_a_t [8] = '{2, 6, 0, 5, 7, 3, 1, 4};
    int spread_b_t [8] = '{3, 5, 7, 0, 6, 1, 4, 2};

    always #4 clk = ~clk;

    always_comb begin
        rx_wires = tx_wires;
        if (fault_en) rx_wires[fault_idx] = 1'b1;
    end

    bundle_repair_switch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_state (cfg_state),
        .tx_data   (tx_data),
        .tx_wires  (tx_wires),
        .rx_wires  (rx_wires),
        .rx_data   (rx_data)
    );

    function automatic int dest(int s, int lane);
        int p;
        if (lane >= 6) return lane + 2;
        case (s % 3)
            1:       p = spread_a_t[lane];
            2:       p = spread_b_t[lane];
            default: p = lane;
        endcase
        if (s >= 3) p = p ^ 1;
        return p;
    endfunction

    function automatic bit parked(int s, int w);
        for (int l = 0; l < 6; l++) if (dest(s, l) == w) return 1'b0;
        return 1'b1;
    endfunction

    function automatic string state_tag(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic load_cfg(input int s);
        @(posedge clk); #1;
        cfg_state = 3'(s);
        cfg_load  = 1'b1;
        @(posedge clk); #1;
        cfg_load  = 1'b0;
        if (s < 6) model_state = s;
    endtask

    task automatic drive(input logic [7:0] d, input bit chk_w,
                         input string tw, input string tr);
        logic [9:0] ew;
        @(posedge clk); #1;
        tx_data = d;
        ew = '0;
        for (int l = 0; l < 8; l++) ew[dest(model_state, l)] = d[l];
        q_w.push_back(ew);
        q_r.push_back(d);
        q_cw.push_back(chk_w);
        q_tw.push_back(tw);
        q_tr.push_back(tr);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (q_r.size() > 0) begin
                logic [9:0] ew;
                logic [7:0] er;
                bit cw;
                string tw, tr;
                ew = q_w.pop_front();
                er = q_r.pop_front();
                cw = q_cw.pop_front();
                tw = q_tw.pop_front();
                tr = q_tr.pop_front();
                if (cw) begin
                    tests++;
                    if (tx_wires !== ew) begin
                        fails++;
                        $display("FAIL %s wires actual %b expected %b", tw, tx_wires, ew);
                    end
                end
                tests++;
                if (rx_data !== er) begin
                    fails++;
                    $display("FAIL %s lanes actual %h expected %h", tr, rx_data, er);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    logic [7:0] pats [5] = '{8'hA5, 8'h3C, 8'hFF, 8'h01, 8'h5A};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        model_state = 0;
        // R1: straight mapping after reset
        drive(8'h2D, 1'b1, "R1", "R7");
        // R6: only spare lanes set, main wires all low
        drive(8'hC0, 1'b1, "R6", "R7");

        for (int s = 0; s < 6; s++) begin
            load_cfg(s);
            for (int p = 0; p < 5; p++) drive(pats[p], 1'b1, state_tag(s), "R7");
            drive(8'hC0, 1'b1, "R6", "R7");
            // R8: stuck-high on every parked wire must not disturb lanes
            for (int w = 0; w < 8; w++) begin
                if (parked(s, w)) begin
                    @(posedge clk); #1;
                    fault_idx = w;
                    fault_en  = 1'b1;
                    drive(8'h00, 1'b0, "R8", "R8");
                    drive(8'h96, 1'b0, "R8", "R8");
                    @(negedge clk);
                    @(negedge clk);
                    fault_en = 1'b0;
                end
            end
        end

        // R10: illegal codes keep the previous state (5)
        load_cfg(6);
        drive(8'h6B, 1'b1, "R10", "R10");
        load_cfg(7);
        drive(8'h94, 1'b1, "R10", "R10");

        // R9: a changed request without the strobe has no effect
        @(posedge clk); #1;
        cfg_state = 3'd1;
        drive(8'h3A, 1'b1, "R9", "R9");
        drive(8'hC5, 1'b1, "R9", "R9");
        // R9: both ends follow the new state from the load edge
        load_cfg(2);
        drive(8'h7E, 1'b1, "R9", "R9");

        // R1: reset mid-run restores straight mapping
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        model_state = 0;
        drive(8'h1F, 1'b1, "R1", "R7");

        while (q_r.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule